// File: doc/BRIEF.md
# Iterative Streaming Top-S Selector

This block finds the S largest unsigned values in a stream of N values. It does not use a wide selector across all N inputs. It has one small selection core with R = G + S inputs and S outputs, and it uses that core again every clock cycle. On each pass the core takes G fresh stream values together with the S survivors of an earlier pass. It keeps the S largest of those R values and sends them back into itself. The only storage for partial results is the core's own pipeline registers, plus one output register that also serves during the final merge.

The core is an input register followed by Q output stages, so a pass takes Q+1 cycles to return. The pipeline therefore holds Q+1 independent partial-result streams in rotation.

A job runs in three phases:
- **Warm-up:** the first Q+1 cycles. Every ring slot gets its first valid entry during this phase.
- **Steady:** fresh groups are accepted until N/G groups have entered.
- **Completion:** the circulating streams are folded together one pair at a time through further core passes, until a single S-value survivor remains.

When the survivor is ready, it is presented on the result port and done pulses once. The result stays on the port until the next start. Core slots that carry no data are filled with zero, so they can never displace a real value.

Top module: `topm_iter_select`

## Requirements
- R1: After reset, done_o is 0, in_ready_o is 0 and every result lane is 0.
- R2: After a start with count N (a multiple of G), in_ready_o stays high until exactly N/G groups have been accepted. An accept is an edge where in_valid_i and in_ready_o are both high. After the last accept, in_ready_o is low.
- R3: When done_o pulses, the result lanes hold the S largest of the N accepted values as a multiset. Lane k is res_o[k*W +: W], and the lanes are in no guaranteed order.
- R4: Repeated values keep their multiplicity: a value that occurs twice among the largest fills two lanes.
- R5: If N < S, or N = 0, the lanes that no input fills read 0.
- R6: Cycles with in_valid_i low do not change the result. This holds whatever in_data_i carries during those cycles.
- R7: done_o is high for exactly one cycle. The result lanes then hold their value until the next start is sampled.
- R8: With in_valid_i held high, done_o rises no later than N/G + (Q+1)·(Q+3) + 6 cycles after the start edge.
- R9: While idle, in_ready_o is 0, and in_valid_i with any data leaves the result unchanged.
- R10: A new start begins a fresh selection. Values from an earlier job never appear in the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a job; sampled only while idle |
| cnt_i | input | CNT_W | Total number of values N, sampled with start_i |
| in_valid_i | input | 1 | A group of G values is present |
| in_ready_o | output | 1 | The block accepts a group this cycle |
| in_data_i | input | G*W | G values; value i is at bits [i*W +: W] |
| done_o | output | 1 | One-cycle pulse when the result is final |
| res_o | output | S*W | S largest values; lane k is at bits [k*W +: W] |

## Verification
Suppose the rotating ring loses a slot or counts one twice, so that a stream is dropped or a merge is skipped. Then a value from one stream never meets the others. This shows at the ports as a wrong multiset on the very done pulse of that job. Data placed so that the largest values fall into different ring slots, or into the first and last groups, exposes this within one job.

A wrong group count shows up earlier, as in_ready_o staying high or dropping too soon. A phase machine that never leaves completion shows up as done_o missing its cycle bound.

// File: rtl/topm_pkg.sv
package topm_pkg;

    // Default geometry: 10-bit values, 4 fresh + 4 feedback lanes, 1 core output stage
    localparam int DEF_W = 10;
    localparam int DEF_G = 4;
    localparam int DEF_S = 4;
    localparam int DEF_Q = 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WARM  = 2'd1,
        PH_RUN   = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

endpackage

// File: rtl/topm_dly.sv
module topm_dly #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/topm_rank_sel.sv
module topm_rank_sel #(
    parameter int W = 10,
    parameter int R = 8,
    parameter int S = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [R*W-1:0] in_flat,
    output logic [S*W-1:0] out_flat
);
    localparam int RW = (R > 1) ? $clog2(R) : 1;

    logic [W-1:0]  v    [R];
    logic [RW-1:0] rank [R];
    logic [R-1:0]  keep;

    for (genvar i = 0; i < R; i++) begin : g_unpack
        assign v[i] = in_flat[i*W +: W];
    end

    // Unique rank: ties broken by lane index, so exactly S lanes are kept
    always_comb begin
        for (int i = 0; i < R; i++) begin
            rank[i] = '0;
            for (int j = 0; j < R; j++) begin
                if (j != i && ((v[j] > v[i]) || (v[j] == v[i] && j < i)))
                    rank[i] = rank[i] + RW'(1);
            end
            keep[i] = (rank[i] < RW'(S));
        end
    end

    for (genvar k = 0; k < S; k++) begin : g_out
        always_comb begin
            out_flat[k*W +: W] = '0;
            for (int i = 0; i < R; i++) begin
                if (rank[i] == RW'(k)) out_flat[k*W +: W] = out_flat[k*W +: W] | v[i];
            end
        end
    end

    AST_KEEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        $countones(keep) == S); // R3
endmodule

// File: rtl/topm_iter_select.sv
module topm_iter_select
    import topm_pkg::*;
#(
    parameter int W     = DEF_W,
    parameter int G     = DEF_G,
    parameter int S     = DEF_S,
    parameter int Q     = DEF_Q,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [G*W-1:0]   in_data_i,
    output logic             done_o,
    output logic [S*W-1:0]   res_o
);
    localparam int R  = G + S;
    localparam int L  = Q + 1;              // ring slots = pass latency
    localparam int LW = $clog2(L + 1);

    initial begin
        if (G < S || Q < 1) $error("topm_iter_select needs G >= S and Q >= 1");
    end

    phase_e           ph;
    logic [CNT_W-1:0] grp_total, grp_cnt;
    logic [LW-1:0]    warm_cnt, live;
    logic [S*W-1:0]   acc;
    logic             acc_v;

    logic             clr, take, finish, capture, merge;
    logic             core_v;
    logic [R*W-1:0]   core_in;
    logic [R*W:0]     s0_q;
    logic [S*W-1:0]   sel_out;
    logic [S*W:0]     pipe_q;
    logic             fb_v;
    logic [S*W-1:0]   fb, fb_d;

    assign clr  = (ph == PH_IDLE) && start_i;
    assign fb_v = pipe_q[S*W];
    assign fb   = pipe_q[S*W-1:0];
    assign fb_d = fb_v ? fb : '0;

    assign in_ready_o = ((ph == PH_WARM) || (ph == PH_RUN)) && (grp_cnt != grp_total);
    assign take       = in_ready_o && in_valid_i;
    assign finish     = (ph == PH_DRAIN) && (live == LW'(1)) && acc_v;

    // Core input assembly: fresh lanes low, fed-back survivors high
    always_comb begin
        core_v  = 1'b0;
        core_in = '0;
        capture = 1'b0;
        merge   = 1'b0;
        case (ph)
            PH_WARM, PH_RUN: begin
                core_v               = 1'b1;
                core_in[G*W-1:0]     = take ? in_data_i : '0;
                core_in[R*W-1:G*W]   = fb_d;
            end
            PH_DRAIN: begin
                if (!finish && fb_v) begin
                    if (acc_v) begin
                        merge              = 1'b1;
                        core_v             = 1'b1;
                        core_in[S*W-1:0]   = acc;
                        core_in[R*W-1:G*W] = fb;
                    end else begin
                        capture = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    topm_dly #(.WIDTH(R*W+1), .DEPTH(1)) i_in_stage (
        .clk(clk), .rst(rst), .clr(clr), .d({core_v, core_in}), .q(s0_q)
    );

    topm_rank_sel #(.W(W), .R(R), .S(S)) i_sel (
        .clk(clk), .rst(rst), .in_flat(s0_q[R*W-1:0]), .out_flat(sel_out)
    );

    topm_dly #(.WIDTH(S*W+1), .DEPTH(Q)) i_out_stage (
        .clk(clk), .rst(rst), .clr(clr), .d({s0_q[R*W], sel_out}), .q(pipe_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            grp_total <= '0;
            grp_cnt   <= '0;
            warm_cnt  <= '0;
            live      <= '0;
            acc       <= '0;
            acc_v     <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start_i) begin
                        grp_total <= CNT_W'(cnt_i / G);
                        grp_cnt   <= '0;
                        warm_cnt  <= '0;
                        acc       <= '0;
                        acc_v     <= 1'b0;
                        ph        <= PH_WARM;
                    end
                end
                PH_WARM: begin
                    grp_cnt  <= grp_cnt + CNT_W'(take);
                    warm_cnt <= warm_cnt + LW'(1);
                    if (warm_cnt == LW'(L - 1)) ph <= PH_RUN;
                end
                PH_RUN: begin
                    grp_cnt <= grp_cnt + CNT_W'(take);
                    if (grp_cnt == grp_total) begin
                        ph   <= PH_DRAIN;
                        live <= LW'(L);
                    end
                end
                PH_DRAIN: begin
                    if (finish) begin
                        ph     <= PH_IDLE;
                        done_o <= 1'b1;
                    end else if (capture) begin
                        acc   <= fb;
                        acc_v <= 1'b1;
                    end else if (merge) begin
                        acc_v <= 1'b0;
                        live  <= live - LW'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign res_o = acc;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && !start_i) |=> $stable(res_o)); // R9
    AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !in_ready_o); // R2
    AST_LIVE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DRAIN) |-> (live >= LW'(1) && live <= LW'(L))); // R3
    AST_GRP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE) |-> (grp_cnt <= grp_total)); // R2
endmodule

// File: tb/test_topm_iter_select.sv
`timescale 1ns/1ps
module test_topm_iter_select;
    localparam int W = 10, G = 4, S = 4, Q = 1, CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] cnt_i = '0;
    logic             in_valid_i = 1'b0;
    logic             in_ready_o;
    logic [G*W-1:0]   in_data_i = '0;
    logic             done_o;
    logic [S*W-1:0]   res_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int vals [64];
    int unsigned seed = 32'h1234_5678;

    topm_iter_select #(.W(W), .G(G), .S(S), .Q(Q), .CNT_W(CNT_W)) i_topm_iter_select (
        .clk(clk), .rst(rst), .start_i(start_i), .cnt_i(cnt_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
        .done_o(done_o), .res_o(res_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_val();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'h3FF);
    endfunction

    // Runs one job on vals[0..n-1]; stall_mod > 0 drops valid every stall_mod-th cycle
    task automatic run_job(input int n, input int stall_mod, input string req);
        int groups, g, lat, viol;
        bit done_seen, acc_now;
        int exp_s [64];
        int act_s [S];
        logic [S*W-1:0] held;
        groups = n / G; g = 0; lat = 0; viol = 0; done_seen = 0;
        @(negedge clk);
        start_i = 1'b1; cnt_i = CNT_W'(n);
        @(negedge clk);
        start_i = 1'b0; lat = 1;
        while (!done_seen && lat < 3000) begin
            if (g < groups && !(stall_mod != 0 && (lat % stall_mod) == 0)) begin
                in_valid_i = 1'b1;
                for (int i = 0; i < G; i++) in_data_i[i*W +: W] = W'(vals[g*G + i]);
            end else begin
                in_valid_i = 1'b0;
                in_data_i  = '1;   // junk that must be ignored (R6)
            end
            if (g >= groups && in_ready_o) viol++;
            acc_now = in_valid_i && in_ready_o;
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (acc_now) g++;
            if (done_o) done_seen = 1'b1;
        end
        in_valid_i = 1'b0;
        chk(done_seen, "R8", {req, " done seen"}, int'(done_seen), 1);
        if (stall_mod == 0)
            chk(lat - 1 <= groups + (Q+1)*(Q+3) + 6, "R8", {req, " latency"}, lat - 1, groups + (Q+1)*(Q+3) + 6);
        chk(g == groups, "R2", {req, " groups accepted"}, g, groups);
        chk(viol == 0, "R2", {req, " ready after last group"}, viol, 0);
        // expected: sort inputs descending, pad with zero
        for (int i = 0; i < 64; i++) exp_s[i] = (i < n) ? vals[i] : 0;
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 63 - i; j++)
                if (exp_s[j] < exp_s[j+1]) begin int t; t = exp_s[j]; exp_s[j] = exp_s[j+1]; exp_s[j+1] = t; end
        for (int k = 0; k < S; k++) act_s[k] = int'(res_o[k*W +: W]);
        for (int i = 0; i < S; i++)
            for (int j = 0; j < S - 1 - i; j++)
                if (act_s[j] < act_s[j+1]) begin int t; t = act_s[j]; act_s[j] = act_s[j+1]; act_s[j+1] = t; end
        for (int k = 0; k < S; k++)
            chk(act_s[k] == exp_s[k], req, $sformatf("rank %0d value", k), act_s[k], exp_s[k]);
        held = res_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R7", {req, " done single cycle"}, int'(done_o), 0);
        chk(res_o == held, "R7", {req, " result held"}, int'(res_o[W-1:0]), int'(held[W-1:0]));
    endtask

    task automatic test_reset();
        chk(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
        chk(in_ready_o == 1'b0, "R1", "ready after reset", int'(in_ready_o), 0);
        chk(res_o == '0, "R1", "result after reset", int'(res_o[W-1:0]), 0);
    endtask

    task automatic test_random();
        for (int i = 0; i < 32; i++) vals[i] = next_val();
        run_job(32, 0, "R3");
    endtask

    task automatic test_ascending();
        for (int i = 0; i < 48; i++) vals[i] = 10 * i + 3;
        run_job(48, 0, "R3");
        for (int i = 0; i < 40; i++) vals[i] = 1000 - 7 * i;   // largest in first group
        run_job(40, 0, "R3");
    endtask

    task automatic test_dups();
        for (int i = 0; i < 24; i++) vals[i] = 7;
        vals[5] = 900; vals[18] = 900;
        run_job(24, 0, "R4");
    endtask

    task automatic test_stall();
        for (int i = 0; i < 36; i++) vals[i] = next_val();
        run_job(36, 3, "R6");
    endtask

    task automatic test_small();
        vals[0] = 5; vals[1] = 3; vals[2] = 9; vals[3] = 1;
        run_job(4, 0, "R5");
        run_job(0, 0, "R5");
    endtask

    task automatic test_idle_ignore();
        logic [S*W-1:0] held;
        int rdy;
        for (int i = 0; i < 8; i++) vals[i] = i + 1;
        run_job(8, 0, "R9");
        held = res_o; rdy = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_valid_i = 1'b1; in_data_i = '1;
            if (in_ready_o) rdy++;
        end
        @(negedge clk);
        in_valid_i = 1'b0;
        chk(rdy == 0, "R9", "ready while idle", rdy, 0);
        chk(res_o == held, "R9", "result unchanged while idle", int'(res_o[W-1:0]), int'(held[W-1:0]));
    endtask

    task automatic test_restart();
        for (int i = 0; i < 16; i++) vals[i] = 1000 + (i % 3);
        run_job(16, 0, "R10");
        for (int i = 0; i < 12; i++) vals[i] = 20 + i;
        run_job(12, 0, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_random();
        test_ascending();
        test_dups();
        test_stall();
        test_small();
        test_idle_ignore();
        test_restart();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule